// File: doc/BRIEF.md
# Hash message input buffer

This block sits in front of a hash compression core and collects the message as a stream of 32-bit words. Each word arrives from a bus write or from a DMA transfer and lands first in a holding register. When the next write arrives, the word already in the holding register moves into a word FIFO, and the new word takes its place. The holding register and the FIFO together form the input buffer, so it holds one word more than the FIFO depth.

The core reads words from the head of the FIFO, oldest first. Each word is byte-reversed on the way out. Words arrive with the first message byte in the lowest byte lane, and the core needs the first message byte in the most significant position. When the FIFO holds a complete block, the block raises a one-cycle ready pulse, and the interrupt line stays high for as long as that block is waiting.

Flow control follows the occupancy of the whole buffer. The DMA request stays high while any slot is free. A write to a full buffer is dropped and sets a sticky overrun flag. A synchronous flush returns the buffer to empty.

Top module: `hash_msg_inbuf`

## Requirements
- R1: A write (wr_en or dma_ack high at a clock edge) that is accepted stores wr_data in the holding register. If the holding register already held a word, that word is appended to the FIFO in the same edge. word_count reports the FIFO entries plus one when the holding register is occupied, from 0 up to DEPTH+1.
- R2: core_word is the oldest FIFO word with its bytes reversed: bits [7:0] appear at [31:24], [15:8] at [23:16], [23:16] at [15:8] and [31:24] at [7:0]. Example: a bus word 0x00636261 is presented as 0x61626300.
- R3: core_pop removes the oldest FIFO word, so words leave in the order they were written. A pop with an empty FIFO has no effect. A pop and an accepted write in the same cycle are both performed.
- R4: blk_ready is high for exactly one cycle: the first cycle in which the FIFO, not counting the holding register, holds DEPTH words.
- R5: buf_full is high exactly when DEPTH+1 words are held. dma_req is high exactly when buf_full is low.
- R6: A write while buf_full is high is dropped, and the stored words are not changed. The dropped write sets overrun, which stays high until flush or reset. Fullness is judged from the state before the edge, so a pop in the same cycle does not make room for the write.
- R7: irq is high while the FIFO holds DEPTH words or overrun is set.
- R8: flush empties the FIFO and the holding register, clears overrun and blk_ready, and takes priority over a write or pop in the same cycle.
- R9: After reset, word_count is 0, dma_req is 1, and buf_full, overrun, irq and blk_ready are 0.
- R10: dma_ack is a write strobe equivalent to wr_en. A cycle with both strobes high writes a single word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous buffer clear |
| wr_en | input | 1 | Bus write strobe for wr_data |
| dma_ack | input | 1 | DMA transfer strobe for wr_data |
| wr_data | input | 32 | Message word, first byte in bits [7:0] |
| core_pop | input | 1 | Core takes the oldest FIFO word |
| core_word | output | 32 | Oldest FIFO word, byte-reversed |
| blk_ready | output | 1 | One-cycle pulse when a full block is present |
| dma_req | output | 1 | Buffer has at least one free slot |
| buf_full | output | 1 | All DEPTH+1 slots occupied |
| irq | output | 1 | Block waiting or overrun |
| overrun | output | 1 | Sticky flag for a dropped write |
| word_count | output | $clog2(DEPTH+2) | Words held, holding register included |

## Verification
The bench builds the block with the default DEPTH of 16, so the 16-word block boundary and the 17-word full point are reached exactly as they would be in use. Traffic alternates between filling, draining and mixed phases, which drives the buffer to full again and again. This exercises the dropped writes, the pop-plus-write cycles that fall on the full point, and repeated block-ready pulses, with flushes scattered among them. A directed start checks the byte reversal with the "abc" word.

// File: rtl/hash_msg_inbuf.sv
module hash_msg_inbuf #(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        wr_en,
  input  logic                        dma_ack,
  input  logic [31:0]                 wr_data,
  input  logic                        core_pop,
  output logic [31:0]                 core_word,
  output logic                        blk_ready,
  output logic                        dma_req,
  output logic                        buf_full,
  output logic                        irq,
  output logic                        overrun,
  output logic [$clog2(DEPTH+2)-1:0]  word_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 2);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fcnt, fcnt_nx;
  logic [31:0]   hold_d, head;
  logic          hold_v, ovr, blk_q;

  wire wr   = wr_en | dma_ack;
  wire take = wr && !buf_full;
  wire push = take && hold_v;
  wire pop  = core_pop && (fcnt != '0);

  assign buf_full   = hold_v && (fcnt == CW'(DEPTH));
  assign dma_req    = !buf_full;
  assign word_count = fcnt + CW'(hold_v);
  assign overrun    = ovr;
  assign blk_ready  = blk_q;
  assign irq        = (fcnt == CW'(DEPTH)) || ovr;
  assign head       = mem[rd_ptr];
  assign core_word  = {head[7:0], head[15:8], head[23:16], head[31:24]};

  always_comb fcnt_nx = fcnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fcnt   <= '0;
      hold_v <= 1'b0;
      hold_d <= '0;
      ovr    <= 1'b0;
      blk_q  <= 1'b0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fcnt   <= '0;
      hold_v <= 1'b0;
      ovr    <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (take) begin
        hold_d <= wr_data;
        hold_v <= 1'b1;
      end
      if (wr && buf_full) ovr <= 1'b1;
      fcnt  <= fcnt_nx;
      blk_q <= (fcnt_nx == CW'(DEPTH)) && (fcnt != CW'(DEPTH));
    end
  end
endmodule

// File: rtl/hash_msg_inbuf_chk.sv
module hash_msg_inbuf_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush,
  input logic                       wr_en,
  input logic                       dma_ack,
  input logic                       core_pop,
  input logic                       blk_ready,
  input logic                       dma_req,
  input logic                       buf_full,
  input logic                       irq,
  input logic                       overrun,
  input logic [$clog2(DEPTH+2)-1:0] word_count
);
  localparam int CW = $clog2(DEPTH + 2);
  wire wr = wr_en | dma_ack;

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_count <= CW'(DEPTH + 1));

  // R1
  wr_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && wr && !core_pop && !buf_full) |=> word_count == CW'($past(word_count) + 1'b1));

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && wr && buf_full && !core_pop) |=> ($stable(word_count) && overrun));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> overrun);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (word_count == '0 && !overrun && !blk_ready));

  // R4
  blk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> word_count >= CW'(DEPTH));

  // R5
  dma_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> word_count <= CW'(DEPTH));

  // R7
  irq_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> irq);
endmodule

bind hash_msg_inbuf hash_msg_inbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .dma_ack(dma_ack),
  .core_pop(core_pop), .blk_ready(blk_ready), .dma_req(dma_req),
  .buf_full(buf_full), .irq(irq), .overrun(overrun), .word_count(word_count)
);

// File: tb/sim_hash_msg_inbuf.sv
`timescale 1ns/1ps
module sim_hash_msg_inbuf;
  localparam int D  = 16;
  localparam int CW = $clog2(D + 2);

  logic clk = 0, rst_n = 0, flush = 0, wr_en = 0, dma_ack = 0, core_pop = 0;
  logic [31:0] wr_data = '0, core_word;
  logic blk_ready, dma_req, buf_full, irq, overrun;
  logic [CW-1:0] word_count;

  always #2 clk = ~clk;

  hash_msg_inbuf #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .dma_ack(dma_ack),
    .wr_data(wr_data), .core_pop(core_pop), .core_word(core_word),
    .blk_ready(blk_ready), .dma_req(dma_req), .buf_full(buf_full), .irq(irq),
    .overrun(overrun), .word_count(word_count)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] q[$];
  bit hv = 0, m_ovr = 0, m_blk = 0;
  logic [31:0] hd = '0;
  bit last_flush = 0, last_dma_only = 0, last_pop = 0;

  function automatic logic [31:0] swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit fl, input bit we, input bit da, input bit pp, input logic [31:0] d);
    int prev = q.size();
    bit full = hv && (q.size() == D);
    flush = fl; wr_en = we; dma_ack = da; core_pop = pp; wr_data = d;
    last_flush = fl; last_dma_only = da && !we; last_pop = pp;
    if (fl) begin
      q.delete(); hv = 0; m_ovr = 0; m_blk = 0;
    end else begin
      if (pp && q.size() > 0) void'(q.pop_front());
      if (we || da) begin
        if (full) m_ovr = 1;
        else begin
          if (hv) q.push_back(hd);
          hd = d; hv = 1;
        end
      end
      m_blk = (q.size() == D) && (prev != D);
    end
  endtask

  task automatic compare();
    int cnt = q.size() + (hv ? 1 : 0);
    chk(last_flush ? "R8" : (last_dma_only ? "R10" : "R1"), 32'(word_count), 32'(cnt));
    chk("R5 full", 32'(buf_full), 32'(cnt == D + 1));
    chk("R5 dma_req", 32'(dma_req), 32'(cnt != D + 1));
    chk("R4", 32'(blk_ready), 32'(m_blk));
    chk("R6", 32'(overrun), 32'(m_ovr));
    chk("R7", 32'(irq), 32'(m_ovr || q.size() == D));
    if (q.size() > 0) chk(last_pop ? "R3" : "R2", core_word, swap(q[0]));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 count", 32'(word_count), 0);
    chk("R9 dma_req", 32'(dma_req), 1);
    chk("R9 flags", {28'b0, buf_full, overrun, irq, blk_ready}, 0);
    rst_n = 1;
    @(negedge clk); compare(); step(0, 1, 0, 0, 32'h00636261);
    @(negedge clk); compare(); step(0, 0, 1, 0, 32'h11223344);
    @(negedge clk); compare();
    chk("R2 abc", core_word, 32'h61626300);
    step(0, 0, 0, 0, '0);
    for (int i = 0; i < 6000; i++) begin
      int ph = (i / 150) % 4;
      int r  = $urandom % 100;
      bit we, da, pp, fl;
      @(negedge clk);
      compare();
      fl = ($urandom % 400) == 0;
      case (ph)
        0: begin we = r < 70; pp = 0; end
        1: begin we = r < 50; pp = ($urandom % 100) < 45; end
        2: begin we = r < 10; pp = ($urandom % 100) < 80; end
        default: begin we = r < 85; pp = ($urandom % 100) < 30; end
      endcase
      da = we && ($urandom % 3 != 0);
      if (da && ($urandom % 2 == 0)) we = 0;
      step(fl, we, da, pp, $urandom);
    end
    @(negedge clk); compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule